// File: doc/BRIEF.md
# Pipelined Converter Code Alignment and Overlap Correction

This block is the digital back end of a pipelined analog-to-digital converter. The converter has four coarse stages and then one flash stage. Each coarse stage resolves a 3-bit code, and each later stage works on the same input sample one clock after the stage before it. The flash stage finishes that sample with a 4-bit code. The codes for one sample therefore reach this block spread over five consecutive clocks.

Each coarse code carries one bit of redundancy. The inter-stage gain is four, so only two of its three bits are new information. The block passes every stage code through a delay line sized to its position, so that all five codes of one sample meet in the same cycle. It then adds the codes at staggered weights. Any decision error that the redundancy can absorb is carried into the upper bits by the addition.

The corrected 12-bit word is clipped at both ends of its range and registered. A valid flag marks the first word whose codes were all captured after reset, and every later word. After that point the block delivers one word per clock.

Top module: `pipeadc_corrector`

## Requirements
- R1: The code of coarse stage k (k = 0 is resolved first) is carried on `stageCodes[3k+2:3k]`. For any one sample, the stage k code is presented k clocks after the stage 0 code, and the flash code is presented 4 clocks after the stage 0 code.
- R2: A synchronous active-high `rst` clears every delay line and the output register. After any clock edge that samples `rst` high, `sampleOut` is 0 and `sampleValid` is 0.
- R3: The corrected value of a sample is stage0·512 + stage1·128 + stage2·32 + stage3·8 + flash − 8. Each coarse stage weighs a quarter of the one before it, and its lowest bit overlaps the next stage's highest bit.
- R4: The word for a sample appears on `sampleOut` just after the clock edge that captures its flash code. That edge is 4 edges after the edge that captured its stage 0 code.
- R5: A corrected value above 4095 is output as 4095.
- R6: A corrected value below 0 is output as 0.
- R7: `sampleValid` stays low for the first 4 edges after reset is released. It is high from the 5th edge on and stays high until the next reset, with a new word on every clock.
- R8: Stage codes come from a quantizer whose first three comparators may each decide one step low, with stage 3 exact and flash = residue + 8. For every such set of codes, the output equals the quantizer's input value exactly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| stageCodes | input | 12 | Four 3-bit coarse stage codes, stage k in bits 3k+2..3k, each skewed by k clocks |
| flashCode | input | 4 | Flash stage code, 4 clocks behind stage 0 |
| sampleOut | output | 12 | Corrected, saturated sample |
| sampleValid | output | 1 | High once every code of the output sample was captured after reset |

## Verification
The hardest situation to reach is a sample whose coarse comparators decided low. The errors have to be large enough to push the residue past a stage's nominal range, yet the codes must still reconstruct the input exactly. A bench quantizer model is therefore driven with random inputs and random one-step low decisions in the first three stages. It produces codes with a real carry between stages, which hand-picked codes seldom give. Codes beyond the legal range are injected directly on a fixed sample cadence to drive the sum past both clip limits. A reset applied while the pipeline is full shows that no stale code leaks into the words that follow.

// File: rtl/pipeadc_pkg.sv
package pipeadc_pkg;

  // Strobes from the control half to the datapath half.
  typedef struct packed {
    logic clearPipe;  // synchronous clear of all storage
    logic markValid;  // pulse: the first fully aligned sample is being captured
  } pipeCtrl_t;

endpackage

// File: rtl/pipeadc_ctrl.sv
module pipeadc_ctrl
  import pipeadc_pkg::*;
#(
  parameter int NSTAGES = 4
) (
  input  logic      clk,
  input  logic      rst,
  output pipeCtrl_t ctrl
);

  // Edges needed after reset before a fully aligned word is captured.
  localparam int FILL  = NSTAGES + 1;
  localparam int CNT_W = $clog2(FILL + 1);

  logic [CNT_W-1:0] fillCnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      fillCnt <= '0;
    end else if (fillCnt != CNT_W'(FILL)) begin
      fillCnt <= fillCnt + 1'b1;
    end
  end

  always_comb begin
    ctrl.clearPipe = rst;
    ctrl.markValid = !rst && (fillCnt == CNT_W'(FILL - 1));
  end

  // R7
  mark_once_chk: assert property (@(posedge clk) disable iff (rst)
    ctrl.markValid |=> !ctrl.markValid);

endmodule

// File: rtl/pipeadc_datapath.sv
module pipeadc_datapath
  import pipeadc_pkg::*;
#(
  parameter int NSTAGES      = 4,
  parameter int CODE_W       = 3,
  parameter int EFF_BITS     = 2,
  parameter int FLASH_W      = 4,
  parameter int FLASH_OFFSET = 8,
  parameter int OUT_W        = 12
) (
  input  logic                        clk,
  input  pipeCtrl_t                   ctrl,
  input  logic [NSTAGES*CODE_W-1:0]   stageCodes,
  input  logic [FLASH_W-1:0]          flashCode,
  output logic [OUT_W-1:0]            sampleOut,
  output logic                        sampleValid
);

  localparam int SUM_W = OUT_W + 2;
  localparam int MAXV  = (1 << OUT_W) - 1;
  localparam logic signed [SUM_W-1:0] MAX_S  = SUM_W'(MAXV);
  localparam logic signed [SUM_W-1:0] ZERO_S = '0;

  logic [CODE_W-1:0] aligned [NSTAGES];

  // Per-stage realignment: stage k waits NSTAGES-k clocks.
  for (genvar k = 0; k < NSTAGES; k++) begin : g_line
    localparam int DEPTH = NSTAGES - k;
    logic [CODE_W-1:0] tap [DEPTH];

    always_ff @(posedge clk) begin
      if (ctrl.clearPipe) begin
        for (int i = 0; i < DEPTH; i++) tap[i] <= '0;
      end else begin
        tap[0] <= stageCodes[k*CODE_W +: CODE_W];
        for (int i = 1; i < DEPTH; i++) tap[i] <= tap[i-1];
      end
    end

    assign aligned[k] = tap[DEPTH-1];
  end

  // Overlapping-bit addition: each later stage sits EFF_BITS lower.
  logic signed [SUM_W-1:0] rawSum;
  always_comb begin
    rawSum = SUM_W'(flashCode) - SUM_W'(FLASH_OFFSET);
    for (int k = 0; k < NSTAGES; k++) begin
      rawSum = rawSum + (SUM_W'(aligned[k]) << (FLASH_W - 1 + EFF_BITS*(NSTAGES - 1 - k)));
    end
  end

  logic [OUT_W-1:0] satVal;
  always_comb begin
    if (rawSum < ZERO_S)      satVal = '0;
    else if (rawSum > MAX_S)  satVal = OUT_W'(MAXV);
    else                      satVal = rawSum[OUT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (ctrl.clearPipe) begin
      sampleOut   <= '0;
      sampleValid <= 1'b0;
    end else begin
      sampleOut   <= satVal;
      sampleValid <= sampleValid | ctrl.markValid;
    end
  end

  // R2
  reset_clear_chk: assert property (@(posedge clk) disable iff (ctrl.clearPipe)
    $past(ctrl.clearPipe) |-> (sampleOut == '0 && !sampleValid));

  // R5
  sat_high_chk: assert property (@(posedge clk) disable iff (ctrl.clearPipe)
    (rawSum > MAX_S) |=> (sampleOut == OUT_W'(MAXV)));

  // R6
  sat_low_chk: assert property (@(posedge clk) disable iff (ctrl.clearPipe)
    (rawSum < ZERO_S) |=> (sampleOut == '0));

  // R7
  valid_hold_chk: assert property (@(posedge clk) disable iff (ctrl.clearPipe)
    sampleValid |=> sampleValid);

endmodule

// File: rtl/pipeadc_corrector.sv
module pipeadc_corrector
  import pipeadc_pkg::*;
#(
  parameter int NSTAGES      = 4,
  parameter int CODE_W       = 3,
  parameter int EFF_BITS     = 2,
  parameter int FLASH_W      = 4,
  parameter int FLASH_OFFSET = 8,
  localparam int OUT_W       = EFF_BITS*NSTAGES + FLASH_W
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NSTAGES*CODE_W-1:0] stageCodes,
  input  logic [FLASH_W-1:0]        flashCode,
  output logic [OUT_W-1:0]          sampleOut,
  output logic                      sampleValid
);

  pipeCtrl_t ctrl;

  pipeadc_ctrl #(.NSTAGES(NSTAGES)) u_ctrl (
    .clk  (clk),
    .rst  (rst),
    .ctrl (ctrl)
  );

  pipeadc_datapath #(
    .NSTAGES      (NSTAGES),
    .CODE_W       (CODE_W),
    .EFF_BITS     (EFF_BITS),
    .FLASH_W      (FLASH_W),
    .FLASH_OFFSET (FLASH_OFFSET),
    .OUT_W        (OUT_W)
  ) u_dp (
    .clk         (clk),
    .ctrl        (ctrl),
    .stageCodes  (stageCodes),
    .flashCode   (flashCode),
    .sampleOut   (sampleOut),
    .sampleValid (sampleValid)
  );

endmodule

// File: tb/pipeadc_corrector_bench.sv
module pipeadc_corrector_bench;

  localparam int NST = 4;
  localparam int CW = 3;
  localparam int FW = 4;
  localparam int OW = 12;
  localparam int OFF = 8;
  localparam int MAXV = 4095;
  localparam int NS = 600;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NST*CW-1:0] stageCodes = '0;
  logic [FW-1:0] flashCode = '0;
  logic [OW-1:0] sampleOut;
  logic sampleValid;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  logic [2:0] sc [NST][NS];
  logic [3:0] fc [NS];
  int xq [NS];
  bit isQ [NS];

  always #5 clk = ~clk;

  pipeadc_corrector u_pipeadc_corrector (
    .clk(clk), .rst(rst), .stageCodes(stageCodes), .flashCode(flashCode),
    .sampleOut(sampleOut), .sampleValid(sampleValid)
  );

  // Reference arithmetic, written from R3/R5/R6.
  function automatic int rawOf(int s);
    int v = int'(fc[s]) - OFF;
    for (int k = 0; k < NST; k++) v += int'(sc[k][s]) * (1 << (9 - 2*k));
    return v;
  endfunction

  function automatic int satOf(int v);
    if (v < 0) return 0;
    if (v > MAXV) return MAXV;
    return v;
  endfunction

  function automatic void setRaw(int s, int a, int b, int c, int d, int f);
    sc[0][s] = 3'(a); sc[1][s] = 3'(b); sc[2][s] = 3'(c); sc[3][s] = 3'(d);
    fc[s] = 4'(f); isQ[s] = 1'b0;
  endfunction

  // Behavioural quantizer model (R8): comparators may decide one step low.
  function automatic void quant(int s, int x, int d0, int d1, int d2);
    int r = x;
    int dd[3] = '{d0, d1, d2};
    for (int k = 0; k < NST; k++) begin
      int w = 1 << (9 - 2*k);
      int c = r / w - ((k < 3) ? dd[k] : 0);
      if (c < 0) c = 0;
      sc[k][s] = 3'(c);
      r -= c * w;
    end
    fc[s] = 4'(r + OFF);
    xq[s] = x;
    isQ[s] = 1'b1;
  endfunction

  function automatic void genSample(int s);
    int r = int'($urandom_range(1023, 0));
    case (s)
      1: setRaw(s, 0, 0, 0, 0, 8);
      2: setRaw(s, 0, 0, 0, 0, 7);
      3: setRaw(s, 0, 0, 0, 0, 0);
      4: setRaw(s, 1, 0, 0, 0, 8);
      5: setRaw(s, 0, 1, 0, 0, 8);
      6: setRaw(s, 0, 0, 1, 0, 8);
      7: setRaw(s, 0, 0, 0, 1, 8);
      8: setRaw(s, 7, 7, 7, 7, 15);
      9: setRaw(s, 7, 4, 0, 0, 8);
      10: setRaw(s, 7, 3, 7, 7, 15);
      11: quant(s, 4095, 0, 0, 0);
      12: quant(s, 0, 0, 0, 0);
      default: begin
        if (s % 17 == 0) setRaw(s, 7, 4 + r % 4, r % 8, (r / 8) % 8, 8 + (r / 64) % 8);
        else if (s % 19 == 0) setRaw(s, 0, 0, 0, 0, r % 8);
        else quant(s, int'($urandom_range(4095, 0)), r % 2, (r / 2) % 2, (r / 4) % 2);
      end
    endcase
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic runPhase(int count, int rlen);
    rst = 1'b1;
    stageCodes = '0;
    flashCode = '0;
    repeat (rlen) begin
      @(posedge clk);
      @(negedge clk);
      check(!sampleValid && sampleOut == '0, "R2 reset clears output and valid",
            int'(sampleOut) + (sampleValid ? 4096 : 0), 0);
    end
    for (int s = 1; s <= count + NST; s++) genSample(s);
    rst = 1'b0;
    for (int n = 1; n <= count + NST; n++) begin
      for (int k = 0; k < NST; k++)
        stageCodes[k*CW +: CW] = (n - k >= 1) ? sc[k][n-k] : 3'd0;
      flashCode = (n - NST >= 1) ? fc[n-NST] : 4'd0;
      @(posedge clk);
      @(negedge clk);
      if (n <= NST) begin
        check(!sampleValid, "R7 valid low while filling", int'(sampleValid), 0);
      end else begin
        int s = n - NST;
        int raw = rawOf(s);
        int exp = satOf(raw);
        string tag;
        if (isQ[s]) tag = "R8 R4 quantized sample";
        else if (raw > MAXV) tag = "R5 R4 clip high";
        else if (raw < 0) tag = "R6 R4 clip low";
        else tag = "R1 R3 R4 weighted sum";
        check(sampleValid, "R7 valid held every clock", int'(sampleValid), 1);
        check(int'(sampleOut) == exp, tag, int'(sampleOut), exp);
        if (isQ[s]) check(int'(sampleOut) == xq[s], "R8 reconstructs quantizer input",
                          int'(sampleOut), xq[s]);
      end
    end
  endtask

  initial begin
    @(negedge clk);
    runPhase(200, 3);
    // Reset while the pipeline is full, held for a single edge.
    runPhase(150, 1);
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule